// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block turns each fetch request from a host into one complete read transaction on a 4-lane serial flash bus. A transaction has up to four phases. An 8-bit command comes first. The address follows. A mode phase can then drive a programmable pattern, with a per-bit enable, or leave the lines floating as dummy cycles. Last comes a data phase that collects one 32-bit word. The command, address and data phases each pick their own lane width: one, two or four lanes.

The block does not generate the serial clock itself. A separate timing block supplies a one-cycle enable, `sck_en_i`, once per serial clock period. Each enable completes one bit slot. All configuration arrives on static input fields. The returned word is presented with a one-cycle valid pulse. `active_o` stays high for as long as a transaction is open, so it can serve directly as the flash select.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset, and at any time no transaction is open, `active_o`, `rvalid_o` and every bit of `sdio_oe_o` are 0.
- R2: A fetch request is taken only when `active_o` is 0. `active_o` rises the cycle after acceptance. A request raised while a transaction is open is ignored and starts no second transaction.
- R3: The command phase sends `cmd_code_i`, 8 bits, most significant first. The lane code selects the width: 0 sends one bit per slot on lane 0, 1 sends two bits on lanes 1:0, and 2 sends four bits on lanes 3:0. Code 3 is treated as 0. The earlier bit always goes on the higher lane, and `sdio_oe_o` enables exactly the lanes in use.
- R4: When `skip_cmd_i` is 1, there is no command phase and the address phase starts immediately.
- R5: The address phase sends `fetch_addr_i[23:0]` when `addr_32b_i` is 0, or all 32 bits when it is 1. Bits go most significant first, with the lane layout of R3 under `addr_lanes_i`.
- R6: The mode phase lasts `mode_clks_i` slots, and a count of 0 removes the phase. Slot k, for k<4, drives `mode_pat_i[15-4k:12-4k]` on lanes 3:0, with the matching bits of `mode_oe_i` as the output enables. Slots 4 and later release every lane.
- R7: The data phase releases every lane and collects 32 bits, most significant first. Single lane samples `sdio_i[1]`. Dual samples `sdio_i[1:0]`. Quad samples `sdio_i[3:0]`, with the higher lane holding the earlier bit. Unused lanes are ignored.
- R8: Received bytes are assembled little-endian: the first byte received lands in `rdata_o[7:0]` and the fourth in `rdata_o[31:24]`.
- R9: The cycle after the final data slot's enable, `rvalid_o` is 1 for exactly one cycle, `rdata_o` holds the word and `active_o` is 0.
- R10: A slot ends only on a cycle with `sck_en_i` high. While the enable is low, the outputs and the transaction hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Request to start a read |
| fetch_addr_i | input | 32 | Read address |
| sck_en_i | input | 1 | One pulse per serial clock slot |
| cmd_code_i | input | 8 | Command byte |
| cmd_lanes_i | input | 2 | Command lane code |
| addr_lanes_i | input | 2 | Address lane code |
| data_lanes_i | input | 2 | Data lane code |
| addr_32b_i | input | 1 | 1: 32-bit address, 0: 24-bit |
| skip_cmd_i | input | 1 | Omit command phase |
| mode_clks_i | input | 4 | Mode phase length in slots |
| mode_pat_i | input | 16 | Mode pattern |
| mode_oe_i | input | 16 | Per-bit enable for the mode pattern |
| sdio_i | input | 4 | Lane inputs |
| sdio_o | output | 4 | Lane outputs |
| sdio_oe_o | output | 4 | Lane output enables |
| active_o | output | 1 | Transaction open |
| rvalid_o | output | 1 | Read word valid pulse |
| rdata_o | output | 32 | Read word |

## Verification
The bench goes after phase boundaries where lane widths change and the bit counter has to step by 1, 2 or 4. If the counter went wrong, a phase would come out one slot long or short, and every later slot would be shifted. Three edge cases are covered: reserved lane code 3, a 24-bit address whose top byte is set and must not be sent, and mode lengths of 0, 1, 4 and 15, where an error would drive lines during dummy slots or skip the pattern. The bench also checks that the byte order flips into little-endian, that junk on the unused input lanes has no effect, that a request arriving mid-transaction is dropped, and that outputs hold while the slot enable is held low.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DATA
  } seq_state_e;

  // lane code -> log2(lanes); reserved code 3 falls back to single
  function automatic logic [1:0] lane_lg(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/flash_rd_tx_shift.sv
module flash_rd_tx_shift
  import flash_rd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             shift_i,
  input  logic [1:0]       lg_i,
  output logic [LANES-1:0] lanes_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_val_i;
    end else if (shift_i) begin
      case (lg_i)
        2'd0:    sr_q <= {sr_q[W-2:0], 1'b0};
        2'd1:    sr_q <= {sr_q[W-3:0], 2'b0};
        default: sr_q <= {sr_q[W-5:0], 4'b0};
      endcase
    end
  end

  always_comb begin
    case (lg_i)
      2'd0:    lanes_o = {3'b0, sr_q[W-1]};
      2'd1:    lanes_o = {2'b0, sr_q[W-1:W-2]};
      default: lanes_o = sr_q[W-1:W-4];
    endcase
  end
endmodule

// File: rtl/flash_rd_mode_drv.sv
module flash_rd_mode_drv
  import flash_rd_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [PAT_W-1:0] oe_i,
  output logic [LANES-1:0] d_o,
  output logic [LANES-1:0] oe_o
);
  localparam int NIB = PAT_W / LANES;

  logic [PAT_W-1:0] pat_sh, oe_sh;

  always_comb begin
    pat_sh = pat_i << (LANES * int'(idx_i));
    oe_sh  = oe_i  << (LANES * int'(idx_i));
    if (int'(idx_i) < NIB) begin
      oe_o = oe_sh[PAT_W-1 -: LANES];
      d_o  = pat_sh[PAT_W-1 -: LANES] & oe_o;
    end else begin
      oe_o = '0;
      d_o  = '0;
    end
  end
endmodule

// File: rtl/flash_rd_rx_gather.sv
module flash_rd_rx_gather
  import flash_rd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       lg_i,
  input  logic [LANES-1:0] sdio_i,
  output logic [W-1:0]     word_o
);
  localparam int NBYTES = W / 8;

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (en_i) begin
      case (lg_i)
        2'd0:    sr_q <= {sr_q[W-2:0], sdio_i[1]};
        2'd1:    sr_q <= {sr_q[W-3:0], sdio_i[1:0]};
        default: sr_q <= {sr_q[W-5:0], sdio_i};
      endcase
    end
  end

  // first byte on the wire sits at the top of sr_q; move it to the bottom
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign word_o[8*b +: 8] = sr_q[W-1-8*b -: 8];
  end
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int CMD_W        = 8,
  parameter int ADDR_W       = 32,
  parameter int SHORT_ADDR_W = 24,
  parameter int DATA_W       = 32,
  parameter int PAT_W        = 16,
  parameter int MCLK_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              sck_en_i,
  input  logic [CMD_W-1:0]  cmd_code_i,
  input  logic [1:0]        cmd_lanes_i,
  input  logic [1:0]        addr_lanes_i,
  input  logic [1:0]        data_lanes_i,
  input  logic              addr_32b_i,
  input  logic              skip_cmd_i,
  input  logic [MCLK_W-1:0] mode_clks_i,
  input  logic [PAT_W-1:0]  mode_pat_i,
  input  logic [PAT_W-1:0]  mode_oe_i,
  input  logic [LANES-1:0]  sdio_i,
  output logic [LANES-1:0]  sdio_o,
  output logic [LANES-1:0]  sdio_oe_o,
  output logic              active_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int MAX_BITS = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  bits_q;
  logic [MCLK_W-1:0] midx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rvalid_q;

  logic [1:0]        lg_now;
  logic [CNT_W-1:0]  step;
  logic              phase_last;
  logic [CNT_W-1:0]  addr_bits;
  logic [ADDR_W-1:0] addr_word, addr_word_new;
  logic              tx_load, tx_shift;
  logic [ADDR_W-1:0] tx_load_val;
  logic [LANES-1:0]  tx_lanes, mode_d, mode_oe;
  logic              rx_en;

  always_comb begin
    case (state_q)
      ST_CMD:  lg_now = lane_lg(cmd_lanes_i);
      ST_ADDR: lg_now = lane_lg(addr_lanes_i);
      ST_DATA: lg_now = lane_lg(data_lanes_i);
      default: lg_now = 2'd0;
    endcase
  end

  assign step       = CNT_W'(1) << lg_now;
  assign phase_last = (bits_q == step);
  assign addr_bits  = addr_32b_i ? CNT_W'(ADDR_W) : CNT_W'(SHORT_ADDR_W);

  // left-align the address so the serializer always shifts from the top
  assign addr_word     = addr_32b_i ? addr_q :
                         {addr_q[SHORT_ADDR_W-1:0], {(ADDR_W-SHORT_ADDR_W){1'b0}}};
  assign addr_word_new = addr_32b_i ? fetch_addr_i :
                         {fetch_addr_i[SHORT_ADDR_W-1:0], {(ADDR_W-SHORT_ADDR_W){1'b0}}};

  always_comb begin
    tx_load     = 1'b0;
    tx_load_val = addr_word;
    if (state_q == ST_IDLE && fetch_req_i) begin
      tx_load     = 1'b1;
      tx_load_val = skip_cmd_i ? addr_word_new :
                    {cmd_code_i, {(ADDR_W-CMD_W){1'b0}}};
    end else if (state_q == ST_CMD && sck_en_i && phase_last) begin
      tx_load     = 1'b1;
      tx_load_val = addr_word;
    end
  end

  assign tx_shift = sck_en_i && (state_q == ST_CMD || state_q == ST_ADDR);
  assign rx_en    = sck_en_i && (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bits_q   <= '0;
      midx_q   <= '0;
      addr_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fetch_req_i) begin
            addr_q <= fetch_addr_i;
            if (skip_cmd_i) begin
              state_q <= ST_ADDR;
              bits_q  <= addr_bits;
            end else begin
              state_q <= ST_CMD;
              bits_q  <= CNT_W'(CMD_W);
            end
          end
        end
        ST_CMD: begin
          if (sck_en_i) begin
            if (phase_last) begin
              state_q <= ST_ADDR;
              bits_q  <= addr_bits;
            end else begin
              bits_q <= bits_q - step;
            end
          end
        end
        ST_ADDR: begin
          if (sck_en_i) begin
            if (phase_last) begin
              if (mode_clks_i != '0) begin
                state_q <= ST_MODE;
                midx_q  <= '0;
              end else begin
                state_q <= ST_DATA;
                bits_q  <= CNT_W'(DATA_W);
              end
            end else begin
              bits_q <= bits_q - step;
            end
          end
        end
        ST_MODE: begin
          if (sck_en_i) begin
            if (midx_q == mode_clks_i - MCLK_W'(1)) begin
              state_q <= ST_DATA;
              bits_q  <= CNT_W'(DATA_W);
            end else begin
              midx_q <= midx_q + MCLK_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (sck_en_i) begin
            if (phase_last) begin
              state_q  <= ST_IDLE;
              rvalid_q <= 1'b1;
            end else begin
              bits_q <= bits_q - step;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  flash_rd_tx_shift #(.W(ADDR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_load),
    .load_val_i (tx_load_val),
    .shift_i    (tx_shift),
    .lg_i       (lg_now),
    .lanes_o    (tx_lanes)
  );

  flash_rd_mode_drv #(.PAT_W(PAT_W), .IDX_W(MCLK_W)) u_mode (
    .idx_i (midx_q),
    .pat_i (mode_pat_i),
    .oe_i  (mode_oe_i),
    .d_o   (mode_d),
    .oe_o  (mode_oe)
  );

  flash_rd_rx_gather #(.W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .lg_i   (lg_now),
    .sdio_i (sdio_i),
    .word_o (rdata_o)
  );

  always_comb begin
    sdio_o    = '0;
    sdio_oe_o = '0;
    case (state_q)
      ST_CMD, ST_ADDR: begin
        sdio_o    = tx_lanes;
        sdio_oe_o = lane_mask(lg_now);
      end
      ST_MODE: begin
        sdio_o    = mode_d;
        sdio_oe_o = mode_oe;
      end
      default: ;
    endcase
  end

  assign active_o = (state_q != ST_IDLE);
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/flash_rd_seq_chk.sv
module flash_rd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fetch_req_i,
  input logic       sck_en_i,
  input logic [3:0] sdio_o,
  input logic [3:0] sdio_oe_o,
  input logic       active_o,
  input logic       rvalid_o
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> sdio_oe_o == 4'b0000); // R1

  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !active_o) |=> active_o); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R9

  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!active_o && $past(active_o) && $past(sck_en_i))); // R9

  AST_HOLD_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !sck_en_i) |=> ($stable(sdio_o) && $stable(sdio_oe_o))); // R10

  AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !sck_en_i) |=> active_o); // R10
endmodule

bind flash_rd_seq flash_rd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_req_i (fetch_req_i),
  .sck_en_i    (sck_en_i),
  .sdio_o      (sdio_o),
  .sdio_oe_o   (sdio_oe_o),
  .active_o    (active_o),
  .rvalid_o    (rvalid_o)
);

// File: tb/tb_flash_rd_seq.sv
module tb_flash_rd_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        sck_en_i = 1'b0;
  logic [7:0]  cmd_code_i = '0;
  logic [1:0]  cmd_lanes_i = '0, addr_lanes_i = '0, data_lanes_i = '0;
  logic        addr_32b_i = 1'b0, skip_cmd_i = 1'b0;
  logic [3:0]  mode_clks_i = '0;
  logic [15:0] mode_pat_i = '0, mode_oe_i = '0;
  logic [3:0]  sdio_i = '0;
  logic [3:0]  sdio_o, sdio_oe_o;
  logic        active_o, rvalid_o;
  logic [31:0] rdata_o;

  always #10 clk_i = ~clk_i;

  flash_rd_seq dut (.*);

  typedef struct packed {
    logic [1:0]  cl, al, dl;
    logic        a32, skip;
    logic [3:0]  mc;
    logic [1:0]  gap;
    logic        inj;
    logic [7:0]  cmd;
    logic [31:0] addr, stream;
    logic [15:0] pat, oe;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  2'd0, 1'b0, 8'h03, 32'h0012_3456, 32'hA1B2_C3D4, 16'h0000, 16'h0000},
    '{2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 4'd6,  2'd1, 1'b1, 8'hEB, 32'h00AB_CDEF, 32'h1234_5678, 16'hF0A5, 16'hFF00},
    '{2'd1, 2'd1, 2'd1, 1'b1, 1'b0, 4'd2,  2'd0, 1'b0, 8'hBB, 32'h8000_0001, 32'h0F1E_2D3C, 16'h5A3C, 16'hF0F0},
    '{2'd0, 2'd2, 2'd2, 1'b1, 1'b1, 4'd4,  2'd2, 1'b0, 8'h00, 32'hDEAD_BEEF, 32'hCAFE_0123, 16'h1234, 16'hFFFF},
    '{2'd3, 2'd3, 2'd3, 1'b1, 1'b0, 4'd1,  2'd0, 1'b1, 8'h3C, 32'h1357_9BDF, 32'h89AB_CDEF, 16'h8000, 16'h8000},
    '{2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 4'd15, 2'd1, 1'b0, 8'h0B, 32'hFF00_ABCD, 32'h55AA_33CC, 16'hFFFF, 16'h000F}
  };

  int total = 0, fails = 0;
  logic [3:0] exp_o [128];
  logic [3:0] exp_oe [128];
  logic [3:0] drv [128];
  int nslots;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lw(input logic [1:0] code);
    return (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
  endfunction

  task automatic push_tx(input logic [31:0] val, input int nbits, input int w);
    logic [31:0] m = (32'd1 << w) - 1;
    for (int s = 0; s < nbits / w; s++) begin
      exp_o[nslots]  = 4'((val >> (nbits - w * (s + 1))) & m);
      exp_oe[nslots] = 4'(m);
      drv[nslots]    = 4'h0;
      nslots++;
    end
  endtask

  task automatic build(input vec_t v);
    logic [31:0] m, val;
    int w;
    nslots = 0;
    if (!v.skip) push_tx({24'h0, v.cmd}, 8, lw(v.cl));
    if (v.a32) push_tx(v.addr, 32, lw(v.al));
    else       push_tx({8'h0, v.addr[23:0]}, 24, lw(v.al));
    for (int k = 0; k < int'(v.mc); k++) begin
      if (k < 4) begin
        exp_oe[nslots] = 4'(v.oe >> (12 - 4 * k));
        exp_o[nslots]  = 4'(v.pat >> (12 - 4 * k)) & exp_oe[nslots];
      end else begin
        exp_oe[nslots] = 4'h0;
        exp_o[nslots]  = 4'h0;
      end
      drv[nslots] = 4'h0;
      nslots++;
    end
    w = lw(v.dl);
    m = (32'd1 << w) - 1;
    for (int s = 0; s < 32 / w; s++) begin
      val = (v.stream >> (32 - w * (s + 1))) & m;
      exp_o[nslots]  = 4'h0;
      exp_oe[nslots] = 4'h0;
      // junk on the lanes the width does not use
      if (w == 1)      drv[nslots] = {~val[0], ~val[0], val[0], ~val[0]};
      else if (w == 2) drv[nslots] = {~val[1], ~val[0], val[1], val[0]};
      else             drv[nslots] = val[3:0];
      nslots++;
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    cmd_code_i = v.cmd; cmd_lanes_i = v.cl; addr_lanes_i = v.al; data_lanes_i = v.dl;
    addr_32b_i = v.a32; skip_cmd_i = v.skip; mode_clks_i = v.mc;
    mode_pat_i = v.pat; mode_oe_i = v.oe; fetch_addr_i = v.addr;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int mism = 0;
    build(v);
    @(negedge clk_i);
    apply_cfg(v);
    fetch_req_i = 1'b1;
    @(negedge clk_i);
    fetch_req_i = 1'b0;
    fetch_addr_i = ~v.addr;
    chk($sformatf("R2 R9 vec%0d active after accept", idx), {31'h0, active_o}, 32'h1);
    for (int k = 0; k < nslots; k++) begin
      for (int g = 0; g < int'(v.gap); g++) begin
        if ((sdio_o & sdio_oe_o) !== exp_o[k] || sdio_oe_o !== exp_oe[k]) mism++;
        @(negedge clk_i);
      end
      if ((sdio_o & sdio_oe_o) !== exp_o[k] || sdio_oe_o !== exp_oe[k]) begin
        if (mism == 0)
          $display("  vec%0d slot %0d: out=%h oe=%h exp out=%h oe=%h",
                   idx, k, sdio_o & sdio_oe_o, sdio_oe_o, exp_o[k], exp_oe[k]);
        mism++;
      end
      sdio_i = drv[k];
      sck_en_i = 1'b1;
      if (v.inj && k == 2) fetch_req_i = 1'b1;
      @(negedge clk_i);
      sck_en_i = 1'b0;
      fetch_req_i = 1'b0;
    end
    chk($sformatf("R3 R4 R5 R6 R7 R10 vec%0d lane stream mismatches", idx), mism, 0);
    chk($sformatf("R9 vec%0d rvalid", idx), {30'h0, rvalid_o, active_o}, 32'h2);
    chk($sformatf("R7 R8 vec%0d rdata", idx), rdata_o,
        {v.stream[7:0], v.stream[15:8], v.stream[23:16], v.stream[31:24]});
    @(negedge clk_i);
    chk($sformatf("R2 R9 vec%0d idle after word", idx),
        {29'h0, rvalid_o, active_o, |sdio_oe_o}, 32'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #5;
    chk("R1 reset state", {29'h0, active_o, rvalid_o, |sdio_oe_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", {28'h0, sdio_oe_o}, 32'h0);
    chk("R1 no valid after reset", {30'h0, active_o, rvalid_o}, 32'h0);

    // R10: no strobe, transaction holds its first slot
    apply_cfg(VECS[0]);
    fetch_req_i = 1'b1;
    @(negedge clk_i);
    fetch_req_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R10 hold without strobe", {27'h0, active_o, sdio_oe_o}, 32'h11);
    chk("R3 first command bit on lane 0", {28'h0, sdio_o}, 32'h0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset mid transaction", {29'h0, active_o, rvalid_o, |sdio_oe_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    finish_run();
  end
endmodule